// File: doc/BRIEF.md
# Interrupt Stacking and Return Sequencer

This block drives the bus of a small 8-bit processor core, with a 16-bit address space, whenever the core takes an exception or leaves one. Interrupt sources are sampled, ranked and captured while the bus is free. When the core signals an instruction boundary, the block takes over the bus. It performs one throw-away read, then saves the return address, the index register, the accumulator and the condition codes on a stack that grows toward lower addresses. It then reads a two-byte vector and fetches the first opcode of the handler. The mask bit in the saved condition-code image is set in the copy it hands back to the core.

On a return request the block reads the same five bytes back in the opposite order, starting just above the current stack pointer. It then fetches the opcode at the restored address and the operand byte after it. Each sequence uses one bus cycle per clock. The updated register values are presented together in the cycle that ends the sequence.

A captured source keeps its claim on the next entry. A later request of higher rank cannot displace it. The claim ends only when the entry starts, or when the mask bit falls while the bus is idle.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset the block is idle: `addr` is 0, `rw` is 1, `wdata` is 0, and `busy` and `done` are 0.
- R2: When idle with a captured source, a high `boundary` starts an entry. The next cycle is a read (`rw`=1) at the `sp_in` value that was sampled with `boundary`.
- R3: The five entry cycles after the dummy read write (`rw`=0) to SP, SP-1, SP-2, SP-3 and SP-4, using 16-bit wrap-around. They carry, in that order, the low byte of `pc_in`-1, its high byte, `x_in`, `a_in` and `ccr_in`. `wdata` is 0 on every read cycle.
- R4: After the writes, the block reads the vector high byte at VEC_TOP-2·code (VEC_TOP = 0xFFFE) and the low byte at the next address. It then fetches at the assembled address with `done`=1. In that cycle `pc_out` holds that address, `sp_out` holds SP-5, `ccr_out` holds the saved codes with bit 3 set, and `a_out`/`x_out` are unchanged.
- R5: `rti_go` while idle starts a return. It reads SP+1..SP+5 into condition codes, A, X, high and low return byte, in that order. It then fetches at the restored address and at that address plus one, with `done`=1 in the last cycle. At that point `sp_out` is SP+5 and the other outputs hold the values that were read.
- R6: `busy` is high on every cycle of a sequence and low otherwise. `rw` is low only on the five stack-write cycles. `done` lasts one cycle.
- R7: Source index 0 (break) and index 1 (software interrupt) are never masked. Indices 2..7 are ignored while `ccr_in` bit 3 is 1. Among eligible sources, the lowest index wins. The winning index is the vector code.
- R8: Once a source is captured, a later higher-ranked request does not change the code used by the next entry.
- R9: A 1-to-0 change of `ccr_in` bit 3 while idle, with no entry starting, drops the capture. The block ranks the sources again one cycle later.
- R10: Sources are captured only while idle. If `boundary` (with a capture) and `rti_go` arrive together, the entry is taken and the return request is ignored.
- R11: A source still pending when a sequence ends is captured in the first idle cycle, and can start the next entry one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 8 | Request levels, index 0 ranks highest |
| boundary | input | 1 | Core is at an instruction boundary |
| rti_go | input | 1 | Core has decoded a return-from-interrupt |
| pc_in | input | 16 | Address of the next instruction |
| sp_in | input | 16 | Current stack pointer |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | Index register |
| ccr_in | input | 8 | Condition codes, bit 3 is the mask |
| rdata | input | 8 | Read data for the current address |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Write data |
| rw | output | 1 | 1 read, 0 write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New index register |
| ccr_out | output | 8 | New condition codes |

## Verification
The assertions assume that `rdata` is valid in the same cycle as `addr`. They also assume that `boundary` and `rti_go` matter only while the block is idle, and that the core holds the register inputs steady in the cycle that starts a sequence. The stimulus applies a new value only on a falling clock edge. It changes the mask bit and the request levels only between sequences, except where it raises a source during an entry on purpose to confirm that the source is not captured there. The memory model returns a fixed function of the address, so every byte read back on a return is known in advance.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    // One state per bus cycle of each sequence.
    typedef enum logic [4:0] {
        ST_IDLE,
        ST_E_DUMMY, ST_E_PCL, ST_E_PCH, ST_E_X, ST_E_A, ST_E_CCR,
        ST_E_VHI, ST_E_VLO, ST_E_FETCH,
        ST_R_CCR, ST_R_A, ST_R_X, ST_R_PCH, ST_R_PCL, ST_R_OP, ST_R_OPND
    } seq_st_e;

endpackage

// File: rtl/irq_arb.sv
module irq_arb #(
    parameter int NSRC    = 8,
    parameter int HW_BASE = 2,
    localparam int CW     = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] req,
    input  logic            imask,
    output logic            any,
    output logic [CW-1:0]   code
);

    logic [NSRC-1:0] elig;

    for (genvar k = 0; k < NSRC; k++) begin : g_gate
        if (k < HW_BASE) begin : g_nomask
            assign elig[k] = req[k];
        end else begin : g_mask
            assign elig[k] = req[k] & ~imask;
        end
    end

    // Lowest index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        code = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (elig[k]) code = CW'(k);
        end
    end

    assign any = |elig;

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
    parameter int             AW      = 16,
    parameter int             CW      = 3,
    parameter logic [AW-1:0]  VEC_TOP = {{(AW-1){1'b1}}, 1'b0}
) (
    input  logic [CW-1:0] code,
    output logic [AW-1:0] hi_addr,
    output logic [AW-1:0] lo_addr
);

    assign hi_addr = VEC_TOP - (AW'(code) << 1);
    assign lo_addr = hi_addr + AW'(1);

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_seq_pkg::*;
#(
    parameter int    DW      = 8,
    parameter int    NSRC    = 8,
    parameter int    HW_BASE = 2,
    parameter int    I_POS   = 3,
    localparam int   AW      = 2 * DW,
    parameter logic [2*DW-1:0] VEC_TOP = {{(2*DW-1){1'b1}}, 1'b0}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            boundary,
    input  logic            rti_go,
    input  logic [AW-1:0]   pc_in,
    input  logic [AW-1:0]   sp_in,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   x_in,
    input  logic [DW-1:0]   ccr_in,
    input  logic [DW-1:0]   rdata,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   wdata,
    output logic            rw,
    output logic            busy,
    output logic            done,
    output logic [AW-1:0]   pc_out,
    output logic [AW-1:0]   sp_out,
    output logic [DW-1:0]   a_out,
    output logic [DW-1:0]   x_out,
    output logic [DW-1:0]   ccr_out
);

    localparam int          CW    = $clog2(NSRC);
    localparam logic [AW-1:0] FRAME = AW'(5);
    localparam logic [DW-1:0] IMASK = DW'(1) << I_POS;

    typedef struct packed {
        seq_st_e         st;
        logic            held_v;
        logic [CW-1:0]   held_code;
        logic            i_prev;
        logic [AW-1:0]   sp;
        logic [DW-1:0]   ra;
        logic [DW-1:0]   rx;
        logic [DW-1:0]   rc;
        logic [DW-1:0]   pch;
        logic [DW-1:0]   pcl;
    } state_t;

    state_t s_d, s_q;

    logic            arb_any;
    logic [CW-1:0]   arb_code;
    logic [AW-1:0]   vec_hi, vec_lo;
    logic [AW-1:0]   ret_addr;
    logic [AW-1:0]   pc_q;
    logic            held_v;
    logic [CW-1:0]   held_code;

    irq_arb #(.NSRC(NSRC), .HW_BASE(HW_BASE)) u_arb (
        .req   (src_req),
        .imask (ccr_in[I_POS]),
        .any   (arb_any),
        .code  (arb_code)
    );

    irq_vec_map #(.AW(AW), .CW(CW), .VEC_TOP(VEC_TOP)) u_vec (
        .code    (s_q.held_code),
        .hi_addr (vec_hi),
        .lo_addr (vec_lo)
    );

    assign ret_addr  = pc_in - AW'(1);
    assign pc_q      = {s_q.pch, s_q.pcl};
    assign held_v    = s_q.held_v;
    assign held_code = s_q.held_code;

    always_comb begin
        s_d        = s_q;
        s_d.i_prev = ccr_in[I_POS];
        addr       = '0;
        wdata      = '0;
        rw         = 1'b1;
        done       = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (boundary && s_q.held_v) begin
                    s_d.st     = ST_E_DUMMY;
                    s_d.held_v = 1'b0;
                    s_d.sp     = sp_in;
                    s_d.ra     = a_in;
                    s_d.rx     = x_in;
                    s_d.rc     = ccr_in;
                    s_d.pch    = ret_addr[AW-1:DW];
                    s_d.pcl    = ret_addr[DW-1:0];
                end else if (rti_go) begin
                    s_d.st = ST_R_CCR;
                    s_d.sp = sp_in;
                end else if (s_q.i_prev && !ccr_in[I_POS]) begin
                    s_d.held_v = 1'b0;
                end else if (!s_q.held_v && arb_any) begin
                    s_d.held_v    = 1'b1;
                    s_d.held_code = arb_code;
                end
            end
            ST_E_DUMMY: begin
                addr   = s_q.sp;
                s_d.st = ST_E_PCL;
            end
            ST_E_PCL: begin
                addr = s_q.sp; wdata = s_q.pcl; rw = 1'b0;
                s_d.st = ST_E_PCH;
            end
            ST_E_PCH: begin
                addr = s_q.sp - AW'(1); wdata = s_q.pch; rw = 1'b0;
                s_d.st = ST_E_X;
            end
            ST_E_X: begin
                addr = s_q.sp - AW'(2); wdata = s_q.rx; rw = 1'b0;
                s_d.st = ST_E_A;
            end
            ST_E_A: begin
                addr = s_q.sp - AW'(3); wdata = s_q.ra; rw = 1'b0;
                s_d.st = ST_E_CCR;
            end
            ST_E_CCR: begin
                addr = s_q.sp - AW'(4); wdata = s_q.rc; rw = 1'b0;
                s_d.rc = s_q.rc | IMASK;
                s_d.sp = s_q.sp - FRAME;
                s_d.st = ST_E_VHI;
            end
            ST_E_VHI: begin
                addr    = vec_hi;
                s_d.pch = rdata;
                s_d.st  = ST_E_VLO;
            end
            ST_E_VLO: begin
                addr    = vec_lo;
                s_d.pcl = rdata;
                s_d.st  = ST_E_FETCH;
            end
            ST_E_FETCH: begin
                addr   = pc_q;
                done   = 1'b1;
                s_d.st = ST_IDLE;
            end
            ST_R_CCR: begin
                addr = s_q.sp + AW'(1); s_d.rc = rdata;
                s_d.st = ST_R_A;
            end
            ST_R_A: begin
                addr = s_q.sp + AW'(2); s_d.ra = rdata;
                s_d.st = ST_R_X;
            end
            ST_R_X: begin
                addr = s_q.sp + AW'(3); s_d.rx = rdata;
                s_d.st = ST_R_PCH;
            end
            ST_R_PCH: begin
                addr = s_q.sp + AW'(4); s_d.pch = rdata;
                s_d.st = ST_R_PCL;
            end
            ST_R_PCL: begin
                addr = s_q.sp + FRAME; s_d.pcl = rdata;
                s_d.sp = s_q.sp + FRAME;
                s_d.st = ST_R_OP;
            end
            ST_R_OP: begin
                addr   = pc_q;
                s_d.st = ST_R_OPND;
            end
            ST_R_OPND: begin
                addr   = pc_q + AW'(1);
                done   = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.st != ST_IDLE);
    assign pc_out  = pc_q;
    assign sp_out  = s_q.sp;
    assign a_out   = s_q.ra;
    assign x_out   = s_q.rx;
    assign ccr_out = s_q.rc;

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          rw,
    input logic          busy,
    input logic          done,
    input logic          held_v,
    input logic [CW-1:0] held_code
);

    // R6: a write cycle only occurs inside a sequence
    a_r6_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> busy);

    // R6: the end marker lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: consecutive stack writes step one address down
    a_r3_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (!rw && $past(!rw)) |-> (addr == $past(addr) - AW'(1)));

    // R3: no stray data on read cycles
    a_r3_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rw |-> (wdata == '0));

    // R2: every sequence opens with a read
    a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rw);

    // R8: a held claim keeps its code
    a_r8_claim_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (held_v && $past(held_v)) |-> (held_code == $past(held_code)));

    // R10: no new claim is taken while a sequence runs
    a_r10_no_claim_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(held_v)) |-> !held_v);

endmodule

bind irq_stack_seq irq_stack_seq_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wdata     (wdata),
    .rw        (rw),
    .busy      (busy),
    .done      (done),
    .held_v    (held_v),
    .held_code (held_code)
);

// File: tb/irq_stack_seq_test.sv
module irq_stack_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_req = '0;
    logic        boundary = 1'b0;
    logic        rti_go = 1'b0;
    logic [15:0] pc_in = 16'h8123;
    logic [15:0] sp_in = 16'h01FF;
    logic [7:0]  a_in = 8'h11;
    logic [7:0]  x_in = 8'h22;
    logic [7:0]  ccr_in = 8'h00;
    logic [7:0]  rdata;
    logic [15:0] addr, pc_out, sp_out;
    logic [7:0]  wdata, a_out, x_out, ccr_out;
    logic        rw, busy, done;

    int errors = 0;
    int checks = 0;
    logic [15:0] last_vec = '0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign rdata = memf(addr);

    irq_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .boundary(boundary),
        .rti_go(rti_go), .pc_in(pc_in), .sp_in(sp_in), .a_in(a_in),
        .x_in(x_in), .ccr_in(ccr_in), .rdata(rdata), .addr(addr),
        .wdata(wdata), .rw(rw), .busy(busy), .done(done), .pc_out(pc_out),
        .sp_out(sp_out), .a_out(a_out), .x_out(x_out), .ccr_out(ccr_out)
    );

    typedef struct {
        logic [15:0] a;
        logic [7:0]  w;
        logic        rw;
        logic        dn;
        logic        vec;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  ra, rx, rc;
        string       tag;
    } exp_t;

    exp_t mq[$];
    logic       m_lv = 1'b0;
    int         m_code = 0;
    logic       m_ip = 1'b0;

    function automatic exp_t mk(input logic [15:0] a, input logic [7:0] w,
                                input logic r, input string tag);
        exp_t e;
        e.a = a; e.w = w; e.rw = r; e.dn = 1'b0; e.vec = 1'b0;
        e.pc = '0; e.sp = '0; e.ra = '0; e.rx = '0; e.rc = '0; e.tag = tag;
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Reference model: decides at each rising edge what the next cycles must look like.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_lv = 1'b0; m_code = 0; m_ip = 1'b0;
        end else begin
            bit idle_now;
            idle_now = (mq.size() == 0);
            if (!idle_now) void'(mq.pop_front());
            if (idle_now) begin
                if (boundary && m_lv) begin
                    logic [15:0] r, va, tgt;
                    exp_t e;
                    r  = pc_in - 16'd1;
                    va = 16'hFFFE - 16'(2 * m_code);
                    tgt = {memf(va), memf(va + 16'd1)};
                    mq.push_back(mk(sp_in, 8'h00, 1'b1, "R2"));
                    mq.push_back(mk(sp_in, r[7:0], 1'b0, "R3"));
                    mq.push_back(mk(sp_in - 16'd1, r[15:8], 1'b0, "R3"));
                    mq.push_back(mk(sp_in - 16'd2, x_in, 1'b0, "R3"));
                    mq.push_back(mk(sp_in - 16'd3, a_in, 1'b0, "R3"));
                    mq.push_back(mk(sp_in - 16'd4, ccr_in, 1'b0, "R3"));
                    e = mk(va, 8'h00, 1'b1, "R4"); e.vec = 1'b1;
                    mq.push_back(e);
                    mq.push_back(mk(va + 16'd1, 8'h00, 1'b1, "R4"));
                    e = mk(tgt, 8'h00, 1'b1, "R4");
                    e.dn = 1'b1; e.pc = tgt; e.sp = sp_in - 16'd5;
                    e.ra = a_in; e.rx = x_in; e.rc = ccr_in | 8'h08;
                    mq.push_back(e);
                    m_lv = 1'b0;
                end else if (rti_go) begin
                    logic [15:0] tgt;
                    exp_t e;
                    tgt = {memf(sp_in + 16'd4), memf(sp_in + 16'd5)};
                    for (int k = 1; k <= 5; k++)
                        mq.push_back(mk(sp_in + 16'(k), 8'h00, 1'b1, "R5"));
                    mq.push_back(mk(tgt, 8'h00, 1'b1, "R5"));
                    e = mk(tgt + 16'd1, 8'h00, 1'b1, "R5");
                    e.dn = 1'b1; e.pc = tgt; e.sp = sp_in + 16'd5;
                    e.rc = memf(sp_in + 16'd1); e.ra = memf(sp_in + 16'd2);
                    e.rx = memf(sp_in + 16'd3);
                    mq.push_back(e);
                end else if (m_ip && !ccr_in[3]) begin
                    m_lv = 1'b0;
                end else if (!m_lv) begin
                    for (int k = 7; k >= 0; k--) begin
                        if (src_req[k] && (k < 2 || !ccr_in[3])) begin
                            m_lv = 1'b1; m_code = k;
                        end
                    end
                end
            end
            m_ip = ccr_in[3];
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            bit ok;
            if (mq.size() != 0) e = mq[0];
            else e = mk(16'h0000, 8'h00, 1'b1, "R6");
            ok = (addr == e.a) && (wdata == e.w) && (rw == e.rw) &&
                 (busy == (mq.size() != 0)) && (done == e.dn);
            if (e.dn)
                ok = ok && (pc_out == e.pc) && (sp_out == e.sp) &&
                     (a_out == e.ra) && (x_out == e.rx) && (ccr_out == e.rc);
            check(ok, e.tag, "bus cycle {addr,wdata,rw,busy,done}",
                  {addr, wdata, rw, busy, done},
                  {e.a, e.w, e.rw, (mq.size() != 0), e.dn});
            if (e.dn && !ok)
                check(1'b0, e.tag, "results {pc,sp,a,x,ccr}",
                      {pc_out, sp_out, a_out, x_out, ccr_out},
                      {e.pc, e.sp, e.ra, e.rx, e.rc});
            if (e.vec) last_vec = addr;
        end
    end

    task automatic tick;
        @(negedge clk);
        #2;
    endtask

    task automatic run_entry;
        boundary = 1'b1;
        tick;
        boundary = 1'b0;
        while (busy) tick;
    endtask

    task automatic run_return(input logic [15:0] sp);
        sp_in = sp;
        rti_go = 1'b1;
        tick;
        rti_go = 1'b0;
        while (busy) tick;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick;
        rst_n = 1'b1;
        // R1: idle after reset
        check(addr == 16'h0 && rw && wdata == 8'h0 && !busy && !done, "R1",
              "reset {addr,wdata,rw,busy,done}", {addr, wdata, rw, busy, done},
              {16'h0, 8'h0, 1'b1, 1'b0, 1'b0});

        // R7: single hardware source, mask clear
        src_req = 8'h10; tick;
        run_entry;
        src_req = 8'h00;
        check(last_vec == 16'hFFF6, "R7", "vector for index 4", last_vec, 16'hFFF6);

        // R8: higher-ranked request after capture is held off
        src_req = 8'h20; tick;
        src_req = 8'h24; tick; tick;
        pc_in = 16'hC000; a_in = 8'h5A; x_in = 8'hA5; ccr_in = 8'h01;
        run_entry;
        src_req = 8'h04;
        check(last_vec == 16'hFFF4, "R8", "held code 5 vector", last_vec, 16'hFFF4);

        // R11: still-pending source captured right after the sequence
        tick;
        run_entry;
        check(last_vec == 16'hFFFA, "R11", "back-to-back index 2", last_vec, 16'hFFFA);
        src_req = 8'h00; ccr_in = 8'h00;

        // R7: masked source ignored, unmaskable one taken
        ccr_in = 8'h08; src_req = 8'h08;
        repeat (3) tick;
        boundary = 1'b1; tick; boundary = 1'b0; tick;
        check(!busy && rw && addr == 16'h0, "R7", "masked source {busy,rw}",
              {busy, rw}, {1'b0, 1'b1});
        src_req = 8'h0A; tick;
        run_entry;
        check(last_vec == 16'hFFFC, "R7", "software source vector", last_vec, 16'hFFFC);
        src_req = 8'h00; tick;

        // R9: mask falling drops the capture and ranks again
        ccr_in = 8'h00; src_req = 8'h40; tick;
        ccr_in = 8'h08; tick;
        src_req = 8'h44; tick;
        ccr_in = 8'h00; tick;
        tick;
        run_entry;
        check(last_vec == 16'hFFFA, "R9", "re-ranked after release", last_vec, 16'hFFFA);
        src_req = 8'h00; tick;

        // R5: return from a known stack position
        run_return(16'h01FA);
        check(sp_out == 16'h01FF, "R5", "sp after return", sp_out, 16'h01FF);

        // R10: entry wins over a simultaneous return; stack wraps (R3)
        src_req = 8'h01; tick;
        src_req = 8'h00;
        sp_in = 16'h0002; pc_in = 16'h0000;
        boundary = 1'b1; rti_go = 1'b1; tick;
        boundary = 1'b0; rti_go = 1'b0;
        check(busy && rw && addr == 16'h0002, "R10", "entry chosen {busy,rw,addr}",
              {busy, rw, addr}, {1'b1, 1'b1, 16'h0002});
        while (busy) tick;
        check(last_vec == 16'hFFFE, "R4", "break vector", last_vec, 16'hFFFE);
        check(sp_out == 16'hFFFD, "R3", "wrapped sp", sp_out, 16'hFFFD);

        // R10: request raised mid-entry does not alter the code in use
        sp_in = 16'h0300; pc_in = 16'h4567;
        src_req = 8'h80; tick;
        boundary = 1'b1; tick; boundary = 1'b0;
        src_req = 8'h81;
        while (busy) tick;
        check(last_vec == 16'hFFF0, "R10", "code kept during entry", last_vec, 16'hFFF0);
        src_req = 8'h01; tick;
        run_entry;
        check(last_vec == 16'hFFFE, "R11", "nested break after sequence", last_vec, 16'hFFFE);
        src_req = 8'h00; tick;

        // Nested returns
        run_return(16'h02F6);
        run_return(16'h02FB);
        check(sp_out == 16'h0300, "R5", "sp after second return", sp_out, 16'h0300);
        repeat (3) tick;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule